// File: doc/BRIEF.md
# Boundary Scan Register Cell Chain

This block is a boundary-register cell and a parameterised chain of such cells. Each cell sits between one chip pin and the core logic. It has two storage stages: a capture/shift flop, which either samples the parallel input or takes the serial bit from the previous cell, and a separate update flop that only changes when an update enable is pulsed. A mode selector chooses what reaches the parallel output. In the functional modes the parallel input passes straight through. In the test modes the update stage drives it, so serial shifting never disturbs the value presented at the pin or core.

The chain links the cells serially. The serial input enters cell 0, each cell feeds the next, and the capture flop of the last cell drives the serial output toward the test data output. All stages run on the rising edge of the test clock and use clock enables, not gated clocks. A synchronous active-high reset clears every stage. TAP state decoding and pad drivers are outside this block and drive its control inputs.

Top module: `bsc_chain`

## Requirements
- R1: A synchronous active-high reset clears the capture stage and the update stage of every cell to 0.
- R2: When `cap_en` is high and `shift_sel` is low at a rising edge, each cell's capture stage loads its bit of `par_in`.
- R3: When `cap_en` is high and `shift_sel` is high at a rising edge, cell 0 loads `ser_in` and cell i loads the old capture value of cell i-1. `ser_out` always shows the capture value of cell N-1.
- R4: When `cap_en` is low, every capture stage holds its value, whatever `shift_sel` and `ser_in` do.
- R5: A rising edge with `upd_en` high copies each capture stage into its update stage. Without it the update stage holds, so shifting or capturing in a test mode leaves `par_out` unchanged.
- R6: `mode` encoding: 0 = normal and 1 = sample, both drive `par_out` = `par_in` combinationally. 2 = external test and 3 = internal test, both drive `par_out` from the update stages.
- R7: In sample mode (1), a capture loads `par_in` while `par_out` keeps following `par_in` undisturbed.
- R8: Chain order: after N shifts, the first bit shifted in sits in cell N-1. After a capture, `ser_out` presents cell N-1's bit first, then N-2, down to cell 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_sel | input | 1 | 1 = shift serial data, 0 = capture parallel data |
| cap_en | input | 1 | Clock enable of the capture/shift stage |
| upd_en | input | 1 | Clock enable of the update stage |
| mode | input | 2 | Output mode: 0 normal, 1 sample, 2 external test, 3 internal test |
| par_in | input | N | Parallel data from the pins or core, one bit per cell |
| ser_in | input | 1 | Serial data into cell 0 |
| par_out | output | N | Parallel data toward the pins or core |
| ser_out | output | 1 | Serial data from cell N-1 |

## Verification
The bench builds the chain with N = 8. With that length a full byte pattern can be shifted in, latched into the update stages and read back on `par_out`, and a captured byte can be shifted out bit by bit, which checks the chain order end to end. Eight cells also make shift-while-holding visible across every position of the chain. All four modes and every pairing of capture and update enables are applied against a behavioural model on every clock.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_EXTEST = 2'd2,
    MODE_INTEST = 2'd3
  } bsc_mode_e;

  function automatic logic mode_is_test(input bsc_mode_e m);
    return (m == MODE_EXTEST) || (m == MODE_INTEST);
  endfunction

endpackage

// File: rtl/bsc_capture_stage.sv
module bsc_capture_stage (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic pin_d,
  input  logic ser_d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (cap_en) begin
      q <= shift_sel ? ser_d : pin_d;
    end
  end

  AST_CAPTURE_PIN: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !shift_sel) |=> (q == $past(pin_d)));                  // R2
  AST_SHIFT_SER: assert property (@(posedge clk) disable iff (rst)
    (cap_en && shift_sel) |=> (q == $past(ser_d)));                   // R3
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(q));                                          // R4

endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (upd_en) begin
      q <= d;
    end
  end

  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (q == $past(d)));                                      // R5
  AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(q));                                          // R5

endmodule

// File: rtl/bsc_mode_mux.sv
module bsc_mode_mux
  import bsc_pkg::*;
(
  input  bsc_mode_e mode,
  input  logic      pin_d,
  input  logic      upd_q,
  output logic      y
);

  always_comb begin
    case (mode)
      MODE_EXTEST, MODE_INTEST: y = upd_q;
      default:                  y = pin_d;
    endcase
  end

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
  import bsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shift_sel,
  input  logic      cap_en,
  input  logic      upd_en,
  input  bsc_mode_e mode,
  input  logic      pin_d,
  input  logic      ser_d,
  output logic      ser_q,
  output logic      par_q
);

  logic cap_q;
  logic upd_q;

  bsc_capture_stage u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .shift_sel (shift_sel),
    .pin_d     (pin_d),
    .ser_d     (ser_d),
    .q         (cap_q)
  );

  bsc_update_stage u_upd (
    .clk    (clk),
    .rst    (rst),
    .upd_en (upd_en),
    .d      (cap_q),
    .q      (upd_q)
  );

  bsc_mode_mux u_mux (
    .mode  (mode),
    .pin_d (pin_d),
    .upd_q (upd_q),
    .y     (par_q)
  );

  assign ser_q = cap_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (cap_q == 1'b0 && upd_q == 1'b0));       // R1

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_sel,
  input  logic         cap_en,
  input  logic         upd_en,
  input  logic [1:0]   mode,
  input  logic [N-1:0] par_in,
  input  logic         ser_in,
  output logic [N-1:0] par_out,
  output logic         ser_out
);

  localparam int LINKS = N + 1;

  bsc_mode_e    mode_e;
  logic [LINKS-1:0] ser_link;

  assign mode_e      = bsc_mode_e'(mode);
  assign ser_link[0] = ser_in;

  for (genvar i = 0; i < N; i++) begin : g_cell
    bsc_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .shift_sel (shift_sel),
      .cap_en    (cap_en),
      .upd_en    (upd_en),
      .mode      (mode_e),
      .pin_d     (par_in[i]),
      .ser_d     (ser_link[i]),
      .ser_q     (ser_link[i+1]),
      .par_q     (par_out[i])
    );
  end

  assign ser_out = ser_link[N];

  AST_TEST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode_is_test(mode_e) && !upd_en) |=>
      (!mode_is_test(mode_e) || $past(rst) || $stable(par_out)));     // R5
  AST_SHIFT_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    (cap_en && shift_sel) |=> (ser_out == $past(ser_link[N-1])));     // R8

endmodule

// File: tb/bsc_chain_test.sv
module bsc_chain_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         shift_sel, cap_en, upd_en, ser_in;
  logic [1:0]   mode;
  logic [N-1:0] par_in;
  logic [N-1:0] par_out;
  logic         ser_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [N-1:0] m_cap = '0;
  logic [N-1:0] m_upd = '0;

  always #4 clk = ~clk;

  bsc_chain #(.N(N)) uut (
    .clk(clk), .rst(rst), .shift_sel(shift_sel), .cap_en(cap_en),
    .upd_en(upd_en), .mode(mode), .par_in(par_in), .ser_in(ser_in),
    .par_out(par_out), .ser_out(ser_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cap <= '0;
      m_upd <= '0;
    end else begin
      if (cap_en) m_cap <= shift_sel ? {m_cap[N-2:0], ser_in} : par_in;
      if (upd_en) m_upd <= m_cap;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  // compare against the model after every clock
  task automatic model_cmp();
    chk("R6 par_out vs model", par_out, (mode >= 2) ? m_upd : par_in);
    chk("R3 ser_out vs model", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_cap[N-1]});
  endtask

  task automatic step(input logic r, input logic ss, input logic ce, input logic ue,
                      input logic [1:0] md, input logic [N-1:0] pin, input logic si);
    rst = r; shift_sel = ss; cap_en = ce; upd_en = ue; mode = md; par_in = pin; ser_in = si;
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] cap_val;
    logic [N-1:0] got;
    rst = 1'b1; shift_sel = 0; cap_en = 0; upd_en = 0; mode = 2'd2; par_in = '1; ser_in = 0;
    @(negedge clk);
    step(1, 0, 0, 0, 2'd2, '1, 0);
    step(0, 0, 0, 0, 2'd2, '1, 0);
    // R1: update stages read back as 0 in test mode, capture as 0 on ser_out
    chk("R1 reset update stages", par_out, '0);
    chk("R1 reset capture tail", {7'b0, ser_out}, '0);

    // R8/R3: shift pattern in, first bit lands in cell N-1
    pat = 8'b1011_0010;
    for (int k = 0; k < N; k++) step(0, 1, 1, 0, 2'd2, 8'h00, pat[N-1-k]);
    chk("R5 no update yet, par_out held", par_out, '0);
    step(0, 0, 0, 1, 2'd2, 8'h00, 0);
    chk("R8 shifted pattern after update", par_out, pat);
    step(0, 0, 0, 0, 2'd3, 8'hFF, 0);
    chk("R6 internal test mode drives update", par_out, pat);

    // R5: shifting in test mode does not disturb par_out
    for (int k = 0; k < N; k++) begin
      step(0, 1, 1, 0, 2'd2, 8'h3C, k[0]);
      chk("R5 par_out stable while shifting", par_out, pat);
    end

    // R4: capture disabled, toggle serial in, ser_out and later update unchanged
    cap_val = {m_cap};
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 2'd2, 8'hA5, ~k[0]);
    step(0, 0, 0, 1, 2'd2, 8'hA5, 0);
    chk("R4 capture held while cap_en low", par_out, 8'b0101_0101);

    // R6: normal mode passes input through
    step(0, 0, 0, 0, 2'd0, 8'h96, 0);
    chk("R6 normal mode pass-through", par_out, 8'h96);
    par_in = 8'h69; #1;
    chk("R6 normal mode combinational", par_out, 8'h69);

    // R7/R2: sample-mode capture, output undisturbed
    step(0, 0, 1, 0, 2'd1, 8'h5A, 0);
    chk("R7 sample mode pass-through during capture", par_out, 8'h5A);

    // R8: shift out, cell N-1 first
    got = '0;
    for (int k = 0; k < N; k++) begin
      got[N-1-k] = ser_out;
      step(0, 1, 1, 0, 2'd1, 8'hC3, 1'b0);
    end
    chk("R2 R8 captured byte shifted out in order", got, 8'h5A);

    // R5: capture and update in one edge, update takes the old capture value
    step(0, 0, 1, 1, 2'd2, 8'hF0, 0);
    chk("R5 update takes pre-capture value", par_out, 8'h00);
    step(0, 0, 0, 1, 2'd2, 8'h00, 0);
    chk("R2 captured value after update", par_out, 8'hF0);

    // R1: mid-run reset
    step(1, 1, 1, 1, 2'd2, 8'hFF, 1);
    chk("R1 mid-run reset clears", par_out, '0);
    step(0, 0, 0, 0, 2'd3, 8'hFF, 0);
    chk("R1 stays clear after reset", par_out, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule